// File: doc/BRIEF.md
# Interrupt Combiner with Timed Deassert

This block merges six interrupt sources into one active-low request line for a host processor. Five of the sources arrive as single-cycle event strobes: key event, keylock, event-queue overflow, and two comparators. The sixth is a bank of general-purpose input pins. Each pin is compared against a programmed trigger level and qualified by its own enable. Every source latches into a sticky status bit. A per-source enable mask decides which latched bits may pull the request line low.

Software acknowledges sources by writing ones to a clear mask. A mode input chooses what the line does when a clear leaves other enabled sources still latched. In hold mode the line simply stays low. In pulse mode the line is released for a fixed 50 microsecond window and then falls again. This gives edge-triggered hosts a fresh falling edge for the work still pending. The window length is derived at elaboration from the clock frequency in kHz.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous reset, all source and pin status bits are 0 and `irq_n_o` is 1.
- R2: A high on `src_evt_i[i]` sets `src_stat_o[i]` on the next cycle. The bits are 0 key, 1 keylock, 2 overflow, 3 comparator 1, 4 comparator 2. Bit 5 of `src_stat_o` is the OR of all `gpio_stat_o` bits.
- R3: `irq_n_o` is registered. It is 0 in the cycle after any `src_stat_o` bit is set whose matching `src_en_i` bit is 1, unless a deassert window is running. A status bit whose enable is 0 has no effect on `irq_n_o`.
- R4: With `clr_valid_i` high, each 1 in `clr_src_i` or `clr_gpio_i` clears the matching status bit on the next cycle. Each 0 leaves its bit unchanged.
- R5: A source event and a clear of the same bit in the same cycle leave that bit set.
- R6: Pin status bit k sets in the cycle after `gpio_ien_i[k]` is 1 and `gpio_in_i[k]` equals `gpio_lvl_i[k]`. It sets again after a clear for as long as that condition holds.
- R7: Pulse mode is `pulse_mode_i`=1. A clear in that mode can start a deassert window when three conditions hold: `irq_n_o` is 0, an enabled status bit remains set after the clear, and no window is running. `irq_n_o` is then 1 for exactly 50*CLK_KHZ/1000 cycles, starting the cycle after the clear, and returns to 0 afterwards if an enabled bit is still set.
- R8: Hold mode is `pulse_mode_i`=0. A clear that leaves an enabled status bit set keeps `irq_n_o` at 0 without a gap.
- R9: Source events during a window are latched into status. Neither events nor further clears shorten or restart the window.
- R10: A clear that removes every enabled status bit returns `irq_n_o` to 1 on the next cycle and starts no window.
- R11: If a pin's level is programmed opposite to its input before its enable is set, enabling that pin sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 5 | Event strobes: key, keylock, overflow, comparator 1, comparator 2 |
| src_en_i | input | 6 | Per-source enable mask; bit 5 is the pin bank |
| pulse_mode_i | input | 1 | 1 selects timed deassert on clear, 0 selects hold |
| gpio_in_i | input | N_GPIO | Pin input levels |
| gpio_lvl_i | input | N_GPIO | Per-pin trigger level |
| gpio_ien_i | input | N_GPIO | Per-pin enable |
| clr_valid_i | input | 1 | Clear strobe from the host |
| clr_src_i | input | 5 | Write-one-to-clear mask for source status bits 0..4 |
| clr_gpio_i | input | N_GPIO | Write-one-to-clear mask for pin status |
| irq_n_o | output | 1 | Active-low combined interrupt request |
| src_stat_o | output | 6 | Source status, bit 5 the OR of pin status |
| gpio_stat_o | output | N_GPIO | Per-pin status |

## Verification
The assertions assume that `src_en_i` is held steady from one cycle to the next whenever its value matters to the request line. They also assume that clears and events arrive as single-cycle strobes rather than held levels. The stimulus changes its inputs only at falling clock edges and drops every clear strobe after one cycle. Pulse-mode clears in the random phase are sparse, so each 5000-cycle window runs to completion and its length can be observed.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  localparam int NUM_EVT = 5;
  localparam int NUM_SRC = NUM_EVT + 1;

  localparam int SRC_KEY  = 0;
  localparam int SRC_LOCK = 1;
  localparam int SRC_OVF  = 2;
  localparam int SRC_CMP1 = 3;
  localparam int SRC_CMP2 = 4;
  localparam int SRC_GPIO = 5;

  function automatic int window_cycles(input int clk_khz, input int win_us);
    int c;
    c = (win_us * clk_khz) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/irq_evt_status.sv
module irq_evt_status #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] stat_o,
  output logic [WIDTH-1:0] stat_nxt_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic q;
    logic d;
    // set dominates a simultaneous clear
    always_comb d = set_i[b] | (q & ~clr_i[b]);
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
    end
    assign stat_o[b]     = q;
    assign stat_nxt_o[b] = d;
  end

endmodule

// File: rtl/irq_gpio_detect.sv
module irq_gpio_detect #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] ien_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] stat_o,
  output logic [N_PINS-1:0] stat_nxt_o,
  output logic              any_o,
  output logic              any_nxt_o
);

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    logic hit;
    logic q;
    logic d;
    always_comb begin
      hit = ien_i[k] & ~(pin_i[k] ^ lvl_i[k]);
      d   = hit | (q & ~clr_i[k]);
    end
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
    end
    assign stat_o[k]     = q;
    assign stat_nxt_o[k] = d;
  end

  assign any_o     = |stat_o;
  assign any_nxt_o = |stat_nxt_o;

endmodule

// File: rtl/irq_deassert_timer.sv
module irq_deassert_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic busy_nxt_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (start_i)            cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign busy_o     = (cnt_q != '0);
  assign busy_nxt_o = (cnt_d != '0);

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_comb_pkg::*;
#(
  parameter int N_GPIO  = 8,
  parameter int CLK_KHZ = 100000,
  parameter int WIN_US  = 50
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EVT-1:0]   src_evt_i,
  input  logic [NUM_SRC-1:0]   src_en_i,
  input  logic                 pulse_mode_i,
  input  logic [N_GPIO-1:0]    gpio_in_i,
  input  logic [N_GPIO-1:0]    gpio_lvl_i,
  input  logic [N_GPIO-1:0]    gpio_ien_i,
  input  logic                 clr_valid_i,
  input  logic [NUM_EVT-1:0]   clr_src_i,
  input  logic [N_GPIO-1:0]    clr_gpio_i,
  output logic                 irq_n_o,
  output logic [NUM_SRC-1:0]   src_stat_o,
  output logic [N_GPIO-1:0]    gpio_stat_o
);

  localparam int PULSE_CYC = window_cycles(CLK_KHZ, WIN_US);

  logic [NUM_EVT-1:0] evt_stat, evt_stat_nxt, evt_clr;
  logic [N_GPIO-1:0]  pin_stat_nxt, pin_clr;
  logic               pin_any, pin_any_nxt;
  logic [NUM_SRC-1:0] stat_nxt;
  logic               pend_nxt;
  logic               pulse_start, pulse_busy, pulse_busy_nxt;
  logic               irq_n_q;

  assign evt_clr = clr_valid_i ? clr_src_i  : '0;
  assign pin_clr = clr_valid_i ? clr_gpio_i : '0;

  irq_evt_status #(.WIDTH(NUM_EVT)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .set_i      (src_evt_i),
    .clr_i      (evt_clr),
    .stat_o     (evt_stat),
    .stat_nxt_o (evt_stat_nxt)
  );

  irq_gpio_detect #(.N_PINS(N_GPIO)) u_gpio (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (gpio_in_i),
    .lvl_i      (gpio_lvl_i),
    .ien_i      (gpio_ien_i),
    .clr_i      (pin_clr),
    .stat_o     (gpio_stat_o),
    .stat_nxt_o (pin_stat_nxt),
    .any_o      (pin_any),
    .any_nxt_o  (pin_any_nxt)
  );

  assign stat_nxt = {pin_any_nxt, evt_stat_nxt};
  assign pend_nxt = |(stat_nxt & src_en_i);

  // window opens only on a clear while the line is asserted and work remains
  assign pulse_start = clr_valid_i & pulse_mode_i & ~irq_n_q & pend_nxt & ~pulse_busy;

  irq_deassert_timer #(.CYCLES(PULSE_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start_i    (pulse_start),
    .busy_o     (pulse_busy),
    .busy_nxt_o (pulse_busy_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~pend_nxt | pulse_busy_nxt;
  end

  assign irq_n_o    = irq_n_q;
  assign src_stat_o = {pin_any, evt_stat};

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int N_GPIO    = 8,
  parameter int PULSE_CYC = 5000
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        src_evt_i,
  input logic [5:0]        src_en_i,
  input logic              pulse_mode_i,
  input logic [N_GPIO-1:0] gpio_in_i,
  input logic [N_GPIO-1:0] gpio_lvl_i,
  input logic [N_GPIO-1:0] gpio_ien_i,
  input logic              irq_n_o,
  input logic [5:0]        src_stat_o,
  input logic [N_GPIO-1:0] gpio_stat_o,
  input logic              pulse_busy
);

  logic [31:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)             run_len <= '0;
    else if (pulse_busy) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (irq_n_o && src_stat_o == '0 && gpio_stat_o == '0));

  // R3
  low_needs_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> |(src_stat_o & $past(src_en_i)));

  // R7
  window_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_busy) |-> irq_n_o);

  // R7
  window_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_busy) |-> run_len == PULSE_CYC);

  // R8
  hold_no_window_chk: assert property (@(posedge clk) disable iff (rst)
    !pulse_mode_i |=> !$rose(pulse_busy));

  for (genvar i = 0; i < 5; i++) begin : g_evt
    // R2 R5
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
      src_evt_i[i] |=> src_stat_o[i]);
  end

  for (genvar k = 0; k < N_GPIO; k++) begin : g_pin
    // R6
    pin_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(gpio_stat_o[k]) |-> $past(gpio_ien_i[k] && (gpio_in_i[k] == gpio_lvl_i[k])));
  end

endmodule

bind irq_combiner irq_combiner_chk #(.N_GPIO(N_GPIO), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_evt_i    (src_evt_i),
  .src_en_i     (src_en_i),
  .pulse_mode_i (pulse_mode_i),
  .gpio_in_i    (gpio_in_i),
  .gpio_lvl_i   (gpio_lvl_i),
  .gpio_ien_i   (gpio_ien_i),
  .irq_n_o      (irq_n_o),
  .src_stat_o   (src_stat_o),
  .gpio_stat_o  (gpio_stat_o),
  .pulse_busy   (pulse_busy)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;

  localparam int NG = 8;
  localparam int KHZ = 100000;
  localparam int PC = (50 * KHZ) / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]    src_evt_i = '0;
  logic [5:0]    src_en_i = '0;
  logic          pulse_mode_i = 1'b0;
  logic [NG-1:0] gpio_in_i = '0;
  logic [NG-1:0] gpio_lvl_i = '0;
  logic [NG-1:0] gpio_ien_i = '0;
  logic          clr_valid_i = 1'b0;
  logic [4:0]    clr_src_i = '0;
  logic [NG-1:0] clr_gpio_i = '0;
  logic          irq_n_o;
  logic [5:0]    src_stat_o;
  logic [NG-1:0] gpio_stat_o;

  always #5 clk = ~clk;

  irq_combiner #(.N_GPIO(NG), .CLK_KHZ(KHZ), .WIN_US(50)) uut (
    .clk(clk), .rst(rst), .src_evt_i(src_evt_i), .src_en_i(src_en_i),
    .pulse_mode_i(pulse_mode_i), .gpio_in_i(gpio_in_i), .gpio_lvl_i(gpio_lvl_i),
    .gpio_ien_i(gpio_ien_i), .clr_valid_i(clr_valid_i), .clr_src_i(clr_src_i),
    .clr_gpio_i(clr_gpio_i), .irq_n_o(irq_n_o), .src_stat_o(src_stat_o),
    .gpio_stat_o(gpio_stat_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit auto_on = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic [4:0]    m_src = '0;
  logic [NG-1:0] m_pin = '0;
  int            m_cnt = 0;
  bit            m_irqn = 1'b1;

  function automatic logic [NG-1:0] pin_hits(input logic [NG-1:0] ien, input logic [NG-1:0] pin, input logic [NG-1:0] lvl);
    return ien & ~(pin ^ lvl);
  endfunction

  always @(posedge clk) begin
    logic [4:0] ns;
    logic [NG-1:0] np;
    logic pend, trig;
    if (rst) begin
      m_src = '0; m_pin = '0; m_cnt = 0; m_irqn = 1'b1;
    end else begin
      ns = (m_src & ~(clr_valid_i ? clr_src_i : 5'd0)) | src_evt_i;
      np = (m_pin & ~(clr_valid_i ? clr_gpio_i : '0)) | pin_hits(gpio_ien_i, gpio_in_i, gpio_lvl_i);
      pend = |({|np, ns} & src_en_i);
      trig = clr_valid_i && pulse_mode_i && !m_irqn && pend && (m_cnt == 0);
      if (trig) m_cnt = PC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_src = ns; m_pin = np;
      m_irqn = !pend || (m_cnt != 0);
    end
  end

  always @(negedge clk) begin
    if (auto_on && !rst) begin
      check(irq_n_o == m_irqn, "R3", irq_n_o, m_irqn);
      check(src_stat_o == {|m_pin, m_src}, "R2", src_stat_o, {|m_pin, m_src});
      check(gpio_stat_o == m_pin, "R6", gpio_stat_o, m_pin);
    end
  end

  task automatic idle();
    src_evt_i = '0; clr_valid_i = 1'b0; clr_src_i = '0; clr_gpio_i = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(irq_n_o == 1'b1, "R1", irq_n_o, 1);
    check(src_stat_o == '0 && gpio_stat_o == '0, "R1", {src_stat_o, gpio_stat_o}, 0);
    auto_on = 1;

    // R2 / R3 masking: key event with source disabled
    src_evt_i = 5'b00001;
    step(1);
    check(src_stat_o[0] == 1'b1, "R2", src_stat_o, 6'h01);
    check(irq_n_o == 1'b1, "R3 masked", irq_n_o, 1);
    src_en_i = 6'h3f;
    step(1);
    check(irq_n_o == 1'b0, "R3", irq_n_o, 0);

    // R4: clearing an unset bit leaves bit0
    clr_valid_i = 1'b1; clr_src_i = 5'b00010;
    step(1);
    check(src_stat_o[0] == 1'b1, "R4", src_stat_o, 6'h01);
    // R10: clear of last pending bit releases line, no window
    clr_valid_i = 1'b1; clr_src_i = 5'b00001; pulse_mode_i = 1'b1;
    step(1);
    check(irq_n_o == 1'b1 && src_stat_o == '0, "R10", {irq_n_o, src_stat_o}, 7'h40);
    step(3);
    check(irq_n_o == 1'b1, "R10", irq_n_o, 1);

    // R5: event and clear together
    src_evt_i = 5'b00100; clr_valid_i = 1'b1; clr_src_i = 5'b00100;
    step(1);
    check(src_stat_o[2] == 1'b1, "R5", src_stat_o, 6'h04);

    // R8: hold mode keeps line low
    pulse_mode_i = 1'b0;
    src_evt_i = 5'b01000;
    step(1);
    clr_valid_i = 1'b1; clr_src_i = 5'b00100;
    step(1);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (irq_n_o) hi++;
      step(1);
    end
    check(hi == 0, "R8", hi, 0);

    // R7 / R9: pulse mode window with mid-window event and clear
    pulse_mode_i = 1'b1;
    clr_valid_i = 1'b1; clr_src_i = 5'b01000; src_evt_i = 5'b00010;
    step(1);
    hi = 0;
    while (irq_n_o && hi < PC + 10) begin
      hi++;
      if (hi == 100) begin
        src_evt_i = 5'b00001; clr_valid_i = 1'b1; clr_src_i = 5'b00010;
        @(negedge clk);
        idle();
      end else begin
        step(1);
      end
    end
    check(hi == PC, "R7", hi, PC);
    check(hi == PC, "R9", hi, PC);
    check(src_stat_o[0] == 1'b1, "R9", src_stat_o, 6'h01);
    check(irq_n_o == 1'b0, "R7", irq_n_o, 0);

    // R11: level programmed before enable
    clr_valid_i = 1'b1; clr_src_i = 5'h1f; pulse_mode_i = 1'b0;
    step(1);
    gpio_in_i = 8'h5a; gpio_lvl_i = 8'ha5;
    step(1);
    gpio_ien_i = 8'hff;
    step(2);
    check(gpio_stat_o == '0 && irq_n_o == 1'b1, "R11", {gpio_stat_o, irq_n_o}, 9'h001);
    // R6: pin 1 matches, stays set while condition holds after clear
    gpio_in_i = 8'h5a ^ 8'h02 ^ 8'h02; gpio_lvl_i = 8'ha7;
    step(1);
    check(gpio_stat_o == 8'h02 && src_stat_o[5], "R6", gpio_stat_o, 8'h02);
    clr_valid_i = 1'b1; clr_gpio_i = 8'h02;
    step(1);
    check(gpio_stat_o == 8'h02, "R6", gpio_stat_o, 8'h02);
    gpio_lvl_i = 8'ha5;
    clr_valid_i = 1'b1; clr_gpio_i = 8'hff;
    step(1);
    check(gpio_stat_o == 8'h00, "R4", gpio_stat_o, 0);

    // random phase
    void'($urandom(32'h1234abcd));
    for (int ph = 0; ph < 2; ph++) begin
      pulse_mode_i = ph[0];
      for (int c = 0; c < (ph == 0 ? 3000 : 22000); c++) begin
        @(negedge clk);
        idle();
        if ($urandom_range(0, 7) == 0) src_evt_i = 5'($urandom);
        if ($urandom_range(0, 15) == 0) src_en_i = 6'($urandom);
        if ($urandom_range(0, 31) == 0) gpio_in_i = NG'($urandom);
        if ($urandom_range(0, 63) == 0) gpio_lvl_i = NG'($urandom);
        if ($urandom_range(0, 63) == 0) gpio_ien_i = NG'($urandom);
        if ($urandom_range(0, ph == 0 ? 5 : 1500) == 0) begin
          clr_valid_i = 1'b1; clr_src_i = 5'($urandom); clr_gpio_i = NG'($urandom);
        end
      end
    end
    step(2);
    summary();
  end

endmodule